// File: doc/BRIEF.md
# Boundary Scan Register with Placeholder Cells

This block is the boundary scan data register for a memory device's I/O ring. An external test access port controller drives it with three strobes (capture, shift, update) and a two-bit decoded instruction. During capture, each functional cell loads the level on its pin. During shift, the cells form one serial path from `tdi` to `tdo`: data moves one cell per rising clock edge, and `tdo` changes on the falling edge.

Some chain positions are fixed placeholder cells. A parameter mask gives their positions. A placeholder cell still forms one stage of the serial path, but it always holds logic one. Any bit that passes through it leaves as a one.

A bank of update latches loads the chain contents on a falling edge. Under external test these latches drive the device output pins. Under the sampling-with-outputs-off instruction, an output-disable signal is raised while the pins continue to be captured.

Top module: `bsr_chain`

## Requirements
- R1: While `rst_n` is low at a rising edge, each chain cell is loaded with its mask bit: placeholders get 1 and functional cells get 0. While `rst_n` is low at a falling edge, the update latches are cleared to 0.
- R2: The instruction codes are 0 = no boundary scan instruction, 1 = sample/preload, 2 = external test, 3 = sample with outputs off. Codes 1 to 3 select the chain. When the chain is selected and `capture_dr` is high at a rising edge, each functional cell at position i loads `pin_in[i]`, and each placeholder cell loads 1. Capture takes priority over shift.
- R3: When the chain is selected and only `shift_dr` is high at a rising edge, cell i loads cell i+1 and the top cell loads `tdi`. Cell 0 is the cell closest to `tdo`. A placeholder cell loads 1 whatever is shifted into it.
- R4: At every falling edge, `tdo` takes the value of chain cell 0.
- R5: When the chain is selected and `update_dr` is high at a falling edge, the update latches load the whole chain. At any other falling edge the latches keep their value.
- R6: With instruction 2, `pin_out` equals the update latches. With any other instruction, `pin_out` equals `func_out`.
- R7: `out_disable` is 1 exactly while the instruction is 3. Capture still takes pin levels under that instruction.
- R8: With instruction 0, the capture, shift and update strobes have no effect: the chain and the latches hold their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; chain on rising edge, tdo and latches on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 2 | Decoded instruction (0 none, 1 sample/preload, 2 external test, 3 sample with outputs off) |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| pin_in | input | CHAIN_LEN | Levels observed on the device pins |
| func_out | input | CHAIN_LEN | Functional values for the output pins |
| tdo | output | 1 | Serial data out |
| pin_out | output | CHAIN_LEN | Values sent to the output pins |
| out_disable | output | 1 | Forces device data outputs to high impedance |

## Verification
A corrupted chain cell shows on `tdo` within CHAIN_LEN shift cycles. Shifting out right after a capture or a reset exposes every position, including the placeholders, which must read as ones. A wrong latch value shows on `pin_out` in the same cycle that external test is selected. A strobe that is wrongly accepted with no instruction active is revealed by the next full shift-out, which then differs from the expected contents. The bench applies the same stimulus to a behavioural model and compares the two after every falling edge.

// File: rtl/bsr_pkg.sv
// Package: shared instruction encoding for the boundary scan register.
// Assumes the TAP controller has already decoded the instruction register
// into this two-bit code.
package bsr_pkg;
    typedef enum logic [1:0] {
        BSR_NONE    = 2'd0,
        BSR_PRELOAD = 2'd1,
        BSR_EXTEST  = 2'd2,
        BSR_SAMPLEZ = 2'd3
    } bsr_instr_e;

    // True when the instruction places the boundary chain between tdi and tdo.
    function automatic logic bsr_selected(input bsr_instr_e code);
        return code != BSR_NONE;
    endfunction
endpackage

// File: rtl/bsr_cell.sv
// Module: one stage of the boundary scan chain.
// A functional stage loads its pin on capture and its upstream neighbour on shift.
// A placeholder stage (IS_PH=1) stays on the serial path but always holds 1.
// Assumes cap_en and shf_en are already qualified by instruction selection.
module bsr_cell #(
    parameter bit IS_PH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shf_en,
    input  logic pin_i,
    input  logic ser_i,
    output logic q_o
);
    localparam logic RST_VAL = IS_PH;

    logic q;

    // Stage register: reset, capture (takes priority) or shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (cap_en)
            q <= IS_PH ? 1'b1 : pin_i;
        else if (shf_en)
            q <= IS_PH ? 1'b1 : ser_i;
    end

    assign q_o = q;
endmodule

// File: rtl/bsr_update_bank.sv
// Module: parallel update latches, loaded on the falling clock edge.
// Assumes load_en is already qualified by instruction selection and update strobe.
module bsr_update_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] lat;

    // Falling-edge latch bank: clear on reset, load on update, otherwise hold.
    always_ff @(negedge clk) begin
        if (!rst_n)
            lat <= '0;
        else if (load_en)
            lat <= d_i;
    end

    assign q_o = lat;

    // R5
    upd_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !load_en |=> $stable(lat));
endmodule

// File: rtl/bsr_pin_mux.sv
// Module: output pin steering.
// Under external test the update latches drive the pins. Under every other
// instruction the functional values pass through. Raises out_disable while
// the sampling-with-outputs-off instruction is active.
module bsr_pin_mux
    import bsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  bsr_instr_e       instr_i,
    input  logic [WIDTH-1:0] upd_i,
    input  logic [WIDTH-1:0] func_i,
    output logic [WIDTH-1:0] pin_o,
    output logic             out_disable_o
);
    // Select the pin source and the disable flag from the instruction.
    always_comb begin
        pin_o         = (instr_i == BSR_EXTEST) ? upd_i : func_i;
        out_disable_o = (instr_i == BSR_SAMPLEZ);
    end
endmodule

// File: rtl/bsr_chain.sv
// Module: boundary scan register top.
// CHAIN_LEN stages form one serial path. Cell 0 is next to tdo and the top
// cell takes tdi. PH_MASK marks the placeholder stages, which always hold 1.
// Assumes capture/shift/update strobes come from a TAP controller and are
// never needed while rst_n is low.
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int                   CHAIN_LEN = 12,
    parameter logic [CHAIN_LEN-1:0] PH_MASK   = 12'h492
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           instr,
    input  logic                 capture_dr,
    input  logic                 shift_dr,
    input  logic                 update_dr,
    input  logic                 tdi,
    input  logic [CHAIN_LEN-1:0] pin_in,
    input  logic [CHAIN_LEN-1:0] func_out,
    output logic                 tdo,
    output logic [CHAIN_LEN-1:0] pin_out,
    output logic                 out_disable
);
    localparam int TOP = CHAIN_LEN - 1;

    bsr_instr_e           instr_e;
    logic                 sel;
    logic                 cap_en;
    logic                 shf_en;
    logic                 upd_en;
    logic [CHAIN_LEN-1:0] chain_q;
    logic [CHAIN_LEN-1:0] ser_in;
    logic [CHAIN_LEN-1:0] upd_q;
    logic                 tdo_q;

    // Qualify the strobes with instruction selection.
    always_comb begin
        instr_e = bsr_instr_e'(instr);
        sel     = bsr_selected(instr_e);
        cap_en  = sel && capture_dr;
        shf_en  = sel && shift_dr;
        upd_en  = sel && update_dr;
    end

    // Serial inputs: each stage takes its upstream neighbour; the top stage takes tdi.
    always_comb begin
        ser_in = {tdi, chain_q[TOP:1]};
    end

    // One stage per chain position; the mask selects the placeholder variant.
    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
        bsr_cell #(.IS_PH(PH_MASK[i])) cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap_en (cap_en),
            .shf_en (shf_en),
            .pin_i  (pin_in[i]),
            .ser_i  (ser_in[i]),
            .q_o    (chain_q[i])
        );
    end

    bsr_update_bank #(.WIDTH(CHAIN_LEN)) upd_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (upd_en),
        .d_i     (chain_q),
        .q_o     (upd_q)
    );

    bsr_pin_mux #(.WIDTH(CHAIN_LEN)) mux_i (
        .instr_i       (instr_e),
        .upd_i         (upd_q),
        .func_i        (func_out),
        .pin_o         (pin_out),
        .out_disable_o (out_disable)
    );

    // Serial output register, updated on the falling edge.
    always_ff @(negedge clk) begin
        tdo_q <= chain_q[0];
    end

    assign tdo = tdo_q;

    // R8
    unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(chain_q));

    // R2
    capture_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && capture_dr) |=> chain_q[0] == (PH_MASK[0] | $past(pin_in[0])));

    // R3
    shift_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift_dr && !capture_dr) |=> chain_q[TOP] == (PH_MASK[TOP] | $past(tdi)));

    // R4
    tdo_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tdo == chain_q[0]);
endmodule

// File: tb/bsr_chain_tb.sv
module bsr_chain_tb_top;
    localparam int N = 12;
    localparam logic [N-1:0] MASK = 12'h492;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   instr = 2'd0;
    logic         capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic [N-1:0] pin_in = '0, func_out = '0;
    logic         tdo;
    logic [N-1:0] pin_out;
    logic         out_disable;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // Behavioural model state.
    bit m_chain[N];
    bit m_upd[N];
    bit m_tdo;

    always #2 clk = ~clk;

    bsr_chain #(.CHAIN_LEN(N), .PH_MASK(MASK)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr(instr), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .pin_in(pin_in),
        .func_out(func_out), .tdo(tdo), .pin_out(pin_out), .out_disable(out_disable)
    );

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // One cycle: drive after rising edge, model falling edge, compare, model rising edge.
    task automatic step(input logic [1:0] ins, input bit cap, input bit shf, input bit upd,
                        input bit d, input logic [N-1:0] pins, input logic [N-1:0] fo,
                        input bit compare);
        bit sel;
        bit nxt[N];
        logic [N-1:0] exp_pins;
        @(posedge clk); #1;
        instr = ins; capture_dr = cap; shift_dr = shf; update_dr = upd;
        tdi = d; pin_in = pins; func_out = fo;
        sel = (ins != 2'd0);
        // falling edge model
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_upd[i] = 0;
        end else if (sel && upd) begin
            for (int i = 0; i < N; i++) m_upd[i] = m_chain[i];
        end
        m_tdo = m_chain[0];
        @(negedge clk); #1;
        if (compare) begin
            for (int i = 0; i < N; i++) exp_pins[i] = (ins == 2'd2) ? m_upd[i] : fo[i];
            chk(cur_req, {{(N-1){1'b0}}, tdo}, {{(N-1){1'b0}}, m_tdo}, "tdo");
            chk(cur_req, pin_out, exp_pins, "pin_out");
            chk(cur_req, {{(N-1){1'b0}}, out_disable}, {{(N-1){1'b0}}, (ins == 2'd3)}, "out_disable");
        end
        // rising edge model
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_chain[i] = MASK[i];
        end else if (sel && cap) begin
            for (int i = 0; i < N; i++) m_chain[i] = MASK[i] ? 1'b1 : pins[i];
        end else if (sel && shf) begin
            for (int i = 0; i < N; i++) nxt[i] = (i == N-1) ? d : m_chain[i+1];
            for (int i = 0; i < N; i++) m_chain[i] = MASK[i] ? 1'b1 : nxt[i];
        end
    endtask

    task automatic shift_out(input logic [1:0] ins, input int cnt);
        for (int k = 0; k < cnt; k++)
            step(ins, 0, 1, 0, 1'($urandom), '0, 12'h0F0, 1);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_chain[i] = MASK[i]; m_upd[i] = 0; end
        m_tdo = 0;
        // Reset
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, '0, '0, 0);
        rst_n = 1'b1;
        // R1: latches cleared, chain shows mask
        cur_req = "R1";
        step(2, 0, 0, 0, 0, '0, 12'hABC, 1);
        shift_out(1, N + 1);
        // R2: capture under preload, then shift out
        cur_req = "R2";
        step(1, 1, 0, 0, 0, 12'h5A3, 12'h111, 1);
        shift_out(1, N);
        step(1, 1, 1, 0, 0, 12'hFFF, 12'h222, 1); // capture wins over shift
        shift_out(1, N);
        // R3/R4: shift patterns through placeholders
        cur_req = "R3";
        for (int k = 0; k < 2 * N; k++) step(1, 0, 1, 0, k[0], '0, '0, 1);
        cur_req = "R4";
        for (int k = 0; k < 2 * N; k++) step(3, 0, 1, 0, 1'($urandom), '0, '0, 1);
        // R5/R6: load latches, then external test drives pins
        cur_req = "R5";
        for (int k = 0; k < N; k++) step(1, 0, 1, 0, 1'($urandom), '0, 12'h333, 1);
        step(1, 0, 0, 1, 0, '0, 12'h333, 1);
        cur_req = "R6";
        step(2, 0, 0, 0, 0, '0, 12'h444, 1);
        step(1, 0, 0, 0, 0, '0, 12'h555, 1);
        for (int k = 0; k < N; k++) step(2, 0, 1, 0, 1'($urandom), '0, 12'h666, 1);
        step(2, 0, 0, 0, 0, '0, 12'h666, 1);
        step(2, 0, 0, 1, 0, '0, 12'h666, 1);
        step(2, 0, 0, 0, 0, '0, 12'h777, 1);
        // R7: outputs off while capturing
        cur_req = "R7";
        step(3, 1, 0, 0, 0, 12'hC3C, 12'h888, 1);
        shift_out(3, N);
        // R8: no instruction ignores all strobes
        cur_req = "R8";
        step(1, 1, 0, 0, 0, 12'h0F0, 12'h0, 1);
        step(0, 1, 0, 1, 0, 12'hF0F, 12'h0, 1);
        for (int k = 0; k < N; k++) step(0, 0, 1, 1, 1, '0, 12'h999, 1);
        step(2, 0, 0, 0, 0, '0, 12'h999, 1);
        shift_out(1, N);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule